// File: doc/BRIEF.md
# Upstream Burst Slot Timing Controller

This block decides the clock cycle in which an upstream burst begins and frames the power amplifier around it. It has two timing sources. In slot mode, a free-running slot counter is re-aligned by each downstream 3 ms marker. On each marker the counter is preloaded with a delay-compensation value from the MAC, so that the local slot grid is advanced by the propagation delay. Slots are then numbered from zero. The MAC arms a request naming a slot number, and the burst starts on the slot pulse that carries that number. In external mode, slot matching is bypassed: every change of level on an external sync pin starts one burst.

Each burst is a fixed sequence. The amplifier enable comes on for a programmable lead time. Then a one-cycle burst-start pulse is sent to the modulator, the burst runs for its programmed length, and the enable stays on for a programmable lag after that. A request written while a burst is in flight is held and armed once the burst ends. A request whose slot has already gone by at the moment it is armed is dropped and reported with a one-cycle flag. The received marker and every slot start are brought out as single-cycle pulses.

Top module: `burst_slot_timer`

## Requirements
- R1: With `ext_mode`=1, bursts start only from `ext_sync` changes, and an armed slot request never starts one. With `ext_mode`=0, changes of `ext_sync` start nothing.
- R2: With `ext_mode`=1 and no burst active, every change of `ext_sync` sampled at a clock edge starts a burst at that edge. This applies to rising and falling changes alike. The stored reference level is 0 after reset, so the first rise to 1 triggers.
- R3: `slot_pulse` is high for exactly one cycle per slot and repeats every `slot_period` cycles. A period of 0 or 1 gives a pulse every cycle.
- R4: `marker_out` is high for exactly one cycle, in the cycle after a rising edge of `marker_in` is sampled, however long `marker_in` stays high.
- R5: A marker loads the slot counter with `comp_val` and sets the slot number to 0. Take the `marker_out` cycle as cycle 0, P as the period and C as the compensation. No slot pulse appears in cycle 0. Slot k pulses in cycle max(P−C,1)+k·P.
- R6: A `req_wr` pulse arms the slot number on `req_slot`. The burst starts at the edge that produces the slot pulse of that number, so the amplifier is active from that slot-pulse cycle onward. One request gives one burst.
- R7: A burst keeps the amplifier active for `lead_cyc` cycles, then for the burst itself, then for `lag_cyc` cycles. The burst lasts `burst_len` cycles, and a length of 0 counts as 1. `burst_start` is high only in the first burst cycle, which is `lead_cyc` cycles after the first active cycle.
- R8: `amp_on` equals `amp_pol` while the amplifier is active and equals its inverse otherwise.
- R9: A request written while a burst is active is held. It is armed in the first cycle with no burst active, and then fires at its slot.
- R10: When a request is armed (idle write or held promotion), it is late if its slot number is below the number of the next slot to come. In that case `late_flag` is high for one cycle in the following cycle and the request is discarded.
- R11: While a burst is active, new triggers are ignored. External changes in that time are lost, and `burst_start` is never high in two adjacent cycles.
- R12: After reset, `marker_out`, `slot_pulse`, `burst_start` and `late_flag` are 0 and `amp_on` equals the inverse of `amp_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 selects external sync timing, 0 selects slot timing |
| ext_sync | input | 1 | External sync; each change starts a burst in external mode |
| marker_in | input | 1 | Received downstream 3 ms marker |
| comp_val | input | CNT_W | Delay compensation preloaded into the slot counter on a marker |
| slot_period | input | CNT_W | Slot length in cycles |
| req_wr | input | 1 | Request write strobe from the MAC |
| req_slot | input | SLOT_W | Target slot number of the request |
| burst_len | input | LEN_W | Burst length in cycles (0 counts as 1) |
| lead_cyc | input | GAP_W | Amplifier lead before burst start |
| lag_cyc | input | GAP_W | Amplifier lag after burst end |
| amp_pol | input | 1 | Active level of `amp_on` |
| marker_out | output | 1 | One-cycle copy of the received marker |
| slot_pulse | output | 1 | One-cycle slot-start pulse |
| burst_start | output | 1 | One-cycle burst-start pulse to the modulator |
| amp_on | output | 1 | Amplifier enable, polarity set by `amp_pol` |
| late_flag | output | 1 | One-cycle flag for a request whose slot has passed |

## Verification
The sweep covers every period from 1 to 6 with every compensation from 0 up to and past the period. This exposes an off-by-one in the reload or the wrap, which would shift every slot pulse and therefore every burst by a cycle. Targets of slot 0 are included, where arming and firing fall on the same edge. Without the same-edge path, such a design would miss the slot and never fire. Lead, length and lag each include zero, so a sequencer that sits one extra cycle in an empty phase shows up as a stretched amplifier window. Held requests are tested on both sides of the cut-off, which catches a design that fires a passed slot or drops a valid one. External runs toggle in both directions and again mid-burst, which catches a design that reacts to only one edge or stacks bursts.

// File: rtl/bst_pkg.sv
package bst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_BURST = 2'd2,
    PH_LAG   = 2'd3
  } phase_e;

  // the counter value seen at this edge is the last one of the slot
  function automatic logic slot_ends(input int unsigned cnt, input int unsigned period);
    return (cnt + 32'd1) >= period;
  endfunction

  // a target below the number of the coming slot can no longer be met
  function automatic logic slot_passed(input int unsigned tgt, input int unsigned next_idx);
    return tgt < next_idx;
  endfunction

  // a zero burst length still occupies one cycle
  function automatic int unsigned burst_cycles(input int unsigned len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

  function automatic logic amp_drive(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction

endpackage

// File: rtl/bst_slot_clock.sv
module bst_slot_clock
  import bst_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              marker_in,
  input  logic [CNT_W-1:0]  comp_val,
  input  logic [CNT_W-1:0]  slot_period,
  output logic              marker_out,
  output logic              slot_pulse,
  output logic              slot_evt,
  output logic [SLOT_W-1:0] slot_idx
);

  logic             mk_q;
  logic             mk_rise;
  logic [CNT_W-1:0] cnt_q;

  assign mk_rise  = marker_in & ~mk_q;
  assign slot_evt = ~mk_rise & slot_ends(32'(cnt_q), 32'(slot_period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_q       <= 1'b0;
      cnt_q      <= '0;
      slot_idx   <= '0;
      marker_out <= 1'b0;
      slot_pulse <= 1'b0;
    end else begin
      mk_q       <= marker_in;
      marker_out <= mk_rise;
      slot_pulse <= slot_evt;
      if (mk_rise) begin
        cnt_q    <= comp_val;
        slot_idx <= '0;
      end else if (slot_evt) begin
        cnt_q    <= '0;
        slot_idx <= slot_idx + 1'b1;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  p_marker_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(marker_in) |=> marker_out);

  p_marker_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    marker_out |=> !marker_out);

  p_slot_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_pulse |=> (!slot_pulse || $past(slot_period) <= 1));

  p_marker_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    marker_out |-> (slot_idx == '0 && !slot_pulse));

endmodule

// File: rtl/bst_req_arm.sv
module bst_req_arm
  import bst_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_en,
  input  logic              req_wr,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic              busy,
  input  logic              slot_evt,
  input  logic [SLOT_W-1:0] slot_idx,
  output logic              std_fire,
  output logic              late_flag
);

  logic              armed_q;
  logic [SLOT_W-1:0] tgt_q;
  logic              held_q;
  logic [SLOT_W-1:0] held_tgt_q;

  logic              arm_go;
  logic [SLOT_W-1:0] arm_tgt;
  logic              arm_late;
  logic              eff_vld;
  logic [SLOT_W-1:0] eff_tgt;

  // arming happens on an idle write or when a held request is released
  assign arm_go   = ~busy & (req_wr | held_q);
  assign arm_tgt  = req_wr ? req_slot : held_tgt_q;
  assign arm_late = arm_go & slot_passed(32'(arm_tgt), 32'(slot_idx));
  assign eff_vld  = arm_go ? ~arm_late : armed_q;
  assign eff_tgt  = arm_go ? arm_tgt : tgt_q;
  assign std_fire = std_en & ~busy & slot_evt & eff_vld & (eff_tgt == slot_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      tgt_q      <= '0;
      held_q     <= 1'b0;
      held_tgt_q <= '0;
      late_flag  <= 1'b0;
    end else begin
      armed_q   <= eff_vld & ~std_fire;
      tgt_q     <= eff_tgt;
      late_flag <= arm_late;
      if (busy & req_wr) begin
        held_q     <= 1'b1;
        held_tgt_q <= req_slot;
      end else if (arm_go) begin
        held_q     <= 1'b0;
      end
    end
  end

  p_late_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    late_flag |-> !armed_q);

  p_fire_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    std_fire |=> !armed_q);

endmodule

// File: rtl/bst_burst_seq.sv
module bst_burst_seq
  import bst_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [GAP_W-1:0] lead_cyc,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [GAP_W-1:0] lag_cyc,
  output logic             busy,
  output logic             burst_start
);

  localparam int SEQ_W = (LEN_W > GAP_W) ? LEN_W : GAP_W;

  phase_e           ph_q, ph_d;
  logic [SEQ_W-1:0] cnt_q, cnt_d;
  logic             bs_d;
  logic [SEQ_W-1:0] len_m1, lead_m1, lag_m1;

  assign len_m1  = SEQ_W'(burst_cycles(32'(burst_len)) - 32'd1);
  assign lead_m1 = SEQ_W'(32'(lead_cyc) - 32'd1);
  assign lag_m1  = SEQ_W'(32'(lag_cyc) - 32'd1);
  assign busy    = (ph_q != PH_IDLE);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    bs_d  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (fire) begin
          if (lead_cyc != '0) begin
            ph_d  = PH_LEAD;
            cnt_d = lead_m1;
          end else begin
            ph_d  = PH_BURST;
            cnt_d = len_m1;
            bs_d  = 1'b1;
          end
        end
      end
      PH_LEAD: begin
        if (cnt_q == '0) begin
          ph_d  = PH_BURST;
          cnt_d = len_m1;
          bs_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_BURST: begin
        if (cnt_q == '0) begin
          if (lag_cyc != '0) begin
            ph_d  = PH_LAG;
            cnt_d = lag_m1;
          end else begin
            ph_d  = PH_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_LAG: begin
        if (cnt_q == '0) ph_d = PH_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      burst_start <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      cnt_q       <= cnt_d;
      burst_start <= bs_d;
    end
  end

  p_start_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (ph_q == PH_BURST));

  p_lead_then_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LEAD && cnt_q == '0) |=> burst_start);

  p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start);

endmodule

// File: rtl/burst_slot_timer.sv
module burst_slot_timer
  import bst_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int SLOT_W = 6,
  parameter int LEN_W  = 8,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              ext_sync,
  input  logic              marker_in,
  input  logic [CNT_W-1:0]  comp_val,
  input  logic [CNT_W-1:0]  slot_period,
  input  logic              req_wr,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [GAP_W-1:0]  lead_cyc,
  input  logic [GAP_W-1:0]  lag_cyc,
  input  logic              amp_pol,
  output logic              marker_out,
  output logic              slot_pulse,
  output logic              burst_start,
  output logic              amp_on,
  output logic              late_flag
);

  logic              slot_evt;
  logic [SLOT_W-1:0] slot_idx;
  logic              std_fire;
  logic              busy;
  logic              sync_q;
  logic              ext_edge;
  logic              ext_fire;
  logic              fire;

  bst_slot_clock #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_clock (
    .clk         (clk),
    .rst_n       (rst_n),
    .marker_in   (marker_in),
    .comp_val    (comp_val),
    .slot_period (slot_period),
    .marker_out  (marker_out),
    .slot_pulse  (slot_pulse),
    .slot_evt    (slot_evt),
    .slot_idx    (slot_idx)
  );

  bst_req_arm #(.SLOT_W(SLOT_W)) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .std_en    (~ext_mode),
    .req_wr    (req_wr),
    .req_slot  (req_slot),
    .busy      (busy),
    .slot_evt  (slot_evt),
    .slot_idx  (slot_idx),
    .std_fire  (std_fire),
    .late_flag (late_flag)
  );

  // the reference level starts at 0, so the first rise of the pin counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= ext_sync;
  end

  assign ext_edge = ext_sync ^ sync_q;
  assign ext_fire = ext_mode & ext_edge & ~busy;
  assign fire     = ext_fire | std_fire;

  bst_burst_seq #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .lead_cyc    (lead_cyc),
    .burst_len   (burst_len),
    .lag_cyc     (lag_cyc),
    .busy        (busy),
    .burst_start (burst_start)
  );

  assign amp_on = amp_drive(busy, amp_pol);

  p_ext_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && ext_edge && !busy) |=> (amp_on == amp_pol));

  p_std_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && ext_edge && !std_fire && !busy) |=> (amp_on != amp_pol));

endmodule

// File: tb/tb_burst_slot_timer.sv
`timescale 1ns/1ps
module tb_burst_slot_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_mode, ext_sync, marker_in, req_wr, amp_pol;
  logic [9:0] comp_val, slot_period;
  logic [5:0] req_slot;
  logic [7:0] burst_len;
  logic [3:0] lead_cyc, lag_cyc;
  logic       marker_out, slot_pulse, burst_start, amp_on, late_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  burst_slot_timer dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .ext_sync(ext_sync),
    .marker_in(marker_in), .comp_val(comp_val), .slot_period(slot_period),
    .req_wr(req_wr), .req_slot(req_slot), .burst_len(burst_len),
    .lead_cyc(lead_cyc), .lag_cyc(lag_cyc), .amp_pol(amp_pol),
    .marker_out(marker_out), .slot_pulse(slot_pulse), .burst_start(burst_start),
    .amp_on(amp_on), .late_flag(late_flag)
  );

  task automatic chk(input string req, input int r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, r, act, exp);
    end
  endtask

  function automatic int amp_exp(input bit act, input bit pol);
    return act ? int'(pol) : int'(!pol);
  endfunction

  // slot mode: marker, request, then compare every cycle with the formulas
  task automatic run_std(input int comp, input int per, input int tgt,
                         input int lead, input int len, input int lag, input bit pol);
    int f, fire_r, tot, lim;
    f      = (comp + 1 >= per) ? 1 : per - comp;
    fire_r = f + tgt * per;
    tot    = lead + ((len == 0) ? 1 : len) + lag;
    lim    = fire_r + tot + per + 2;
    @(negedge clk);
    ext_mode = 0; comp_val = 10'(comp); slot_period = 10'(per);
    burst_len = 8'(len); lead_cyc = 4'(lead); lag_cyc = 4'(lag); amp_pol = pol;
    marker_in = 1;
    @(negedge clk);
    chk("R4 marker echo", 0, int'(marker_out), 1);
    chk("R5 no slot pulse on marker", 0, int'(slot_pulse), 0);
    marker_in = 0; req_wr = 1; req_slot = 6'(tgt);
    for (int r = 1; r <= lim; r++) begin
      @(negedge clk);
      if (r == 1) req_wr = 0;
      chk("R3 R5 slot pulse", r, int'(slot_pulse), int'(r >= f && ((r - f) % per) == 0));
      chk("R6 R7 R8 amp window", r, int'(amp_on), amp_exp(r >= fire_r && r < fire_r + tot, pol));
      chk("R7 burst start", r, int'(burst_start), int'(r == fire_r + lead));
      chk("R4 marker single", r, int'(marker_out), 0);
      chk("R10 no late", r, int'(late_flag), 0);
    end
  endtask

  // request written in the middle of a long burst
  task automatic run_queue(input int tgt2);
    int f, per, fire1, tot, end1, fire2, lim;
    bit late;
    per = 4; f = 4; fire1 = f + per; tot = 1 + 10 + 1; end1 = fire1 + tot - 1;
    late  = (f + tgt2 * per) <= end1 + 1;
    fire2 = f + tgt2 * per;
    lim   = 50;
    @(negedge clk);
    ext_mode = 0; comp_val = 0; slot_period = 10'(per);
    burst_len = 10; lead_cyc = 1; lag_cyc = 1; amp_pol = 1; marker_in = 1;
    @(negedge clk);
    marker_in = 0; req_wr = 1; req_slot = 1;
    for (int r = 1; r <= lim; r++) begin
      bit act;
      @(negedge clk);
      req_wr = (r == 10);
      if (r == 10) req_slot = 6'(tgt2);
      act = (r >= fire1 && r <= end1) || (!late && r >= fire2 && r < fire2 + tot);
      chk("R9 amp window with held request", r, int'(amp_on), amp_exp(act, 1));
      chk("R9 burst start with held request", r, int'(burst_start),
          int'(r == fire1 + 1 || (!late && r == fire2 + 1)));
      chk("R10 late flag on promotion", r, int'(late_flag), int'(late && r == end1 + 2));
    end
  endtask

  // request written while idle after several slots have gone by
  task automatic run_idle_arm(input int tgt);
    int per, f, fire_r;
    bit late;
    per = 3; f = 3;
    late   = (f + tgt * per) <= 10;
    fire_r = f + tgt * per;
    @(negedge clk);
    ext_mode = 0; comp_val = 0; slot_period = 10'(per);
    burst_len = 2; lead_cyc = 0; lag_cyc = 0; amp_pol = 0; marker_in = 1;
    @(negedge clk);
    marker_in = 0;
    for (int r = 1; r <= 25; r++) begin
      @(negedge clk);
      req_wr = (r == 10);
      if (r == 10) req_slot = 6'(tgt);
      chk("R10 idle late flag", r, int'(late_flag), int'(late && r == 11));
      chk("R10 R6 amp after idle write", r, int'(amp_on),
          amp_exp(!late && r >= fire_r && r < fire_r + 2, 0));
    end
  endtask

  // external mode: one change of level, optionally a second one mid-burst
  task automatic run_ext(input int lead, input int len, input int lag, input bit pol,
                         input int second_rel);
    int tot;
    tot = lead + ((len == 0) ? 1 : len) + lag;
    @(negedge clk);
    ext_mode = 1; burst_len = 8'(len); lead_cyc = 4'(lead); lag_cyc = 4'(lag);
    amp_pol = pol; ext_sync = ~ext_sync;
    for (int r = 1; r <= tot + 4; r++) begin
      @(negedge clk);
      if (r == second_rel) ext_sync = ~ext_sync;
      chk(second_rel != 0 ? "R11 toggle during burst ignored" : "R2 external amp window",
          r, int'(amp_on), amp_exp(r >= 1 && r <= tot, pol));
      chk("R2 R7 external burst start", r, int'(burst_start), int'(r == 1 + lead));
    end
  endtask

  // each mode ignores the other timing source
  task automatic run_isolation();
    @(negedge clk);
    ext_mode = 1; comp_val = 0; slot_period = 2; burst_len = 1;
    lead_cyc = 0; lag_cyc = 0; amp_pol = 1; marker_in = 1;
    @(negedge clk);
    marker_in = 0; req_wr = 1; req_slot = 1;
    for (int r = 1; r <= 10; r++) begin
      @(negedge clk);
      req_wr = 0;
      chk("R1 slot request ignored in external mode", r, int'(amp_on), 0);
    end
    @(negedge clk);
    ext_mode = 0; ext_sync = ~ext_sync;
    for (int r = 1; r <= 6; r++) begin
      @(negedge clk);
      chk("R1 sync change ignored in slot mode", r, int'(amp_on), 0);
    end
  endtask

  initial begin
    rst_n = 0; ext_mode = 0; ext_sync = 0; marker_in = 0; req_wr = 0; amp_pol = 1;
    comp_val = 0; slot_period = 50; req_slot = 0; burst_len = 1; lead_cyc = 0; lag_cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset marker_out", 0, int'(marker_out), 0);
    chk("R12 reset slot_pulse", 0, int'(slot_pulse), 0);
    chk("R12 reset burst_start", 0, int'(burst_start), 0);
    chk("R12 reset amp_on", 0, int'(amp_on), 0);
    chk("R12 reset late_flag", 0, int'(late_flag), 0);

    for (int per = 1; per <= 6; per++)
      for (int comp = 0; comp <= per; comp++)
        for (int tgt = 0; tgt <= 2; tgt++)
          run_std(comp, per, tgt, (per + comp) % 3, (comp + tgt) % 4, tgt % 3,
                  bit'((per + tgt) % 2));

    run_queue(2);
    run_queue(4);
    run_queue(5);
    run_queue(7);
    run_idle_arm(2);
    run_idle_arm(3);

    for (int lead = 0; lead <= 2; lead++)
      for (int len = 0; len <= 2; len++)
        for (int lag = 0; lag <= 2; lag++)
          run_ext(lead, len, lag, bit'((lead + lag) % 2), 0);
    run_ext(1, 3, 1, 1, 2);
    run_ext(0, 2, 2, 0, 3);
    run_isolation();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not end)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule